// File: doc/BRIEF.md
# Receive Ring Packet Writer

This block is the write half of a network receive path. Frames arrive as a byte stream that an address filter has already classified. Each frame is written into a circular byte buffer held in on-chip RAM. The block keeps its own write offset. The host tells it how far it has consumed the buffer through a biased read-pointer register. The block reports a buffer-empty flag, and it raises a one-cycle event when a frame is stored, stored with errors, or lost for lack of room.

Each stored frame takes a four-byte little-endian header followed by the frame bytes, FCS included. The header is written in a single cycle after the last byte has arrived, so the host never finds a valid header in front of a partly written frame. Frames always begin on a four-byte boundary. An optional linear mode lets a frame run past the end of the ring into a small slack area instead of folding back to offset zero, so the host can read every frame as one contiguous block.

Top module: `rxr_writer`

## Requirements
- R1: After reset, `buf_empty` is 1, no event output is high, the write offset is 0 and the read pointer register holds 0xFFF0, so the biased read offset is 0. The configuration register resets to 0, which accepts nothing.
- R2: A committed frame that starts at offset S has its header at bytes S..S+3, little-endian. Bits 15:0 are the status word and bits 31:16 are the byte count including FCS. Frame byte i is at S+4+i. The header is written in the cycle after the last byte is sampled. The block needs one idle input cycle after each last byte.
- R3: The status word has bit 0 good, bit 1 alignment error, bit 2 CRC error, bit 3 too long (length > MAX_LEN), bit 4 runt (length < MIN_LEN), bit 5 symbol error, bit 13 broadcast, bit 14 own-address match and bit 15 multicast. The good bit is set only when bits 1 to 5 are all clear.
- R4: After a committed frame of length L at S, the write offset becomes (S + L + 7) with its two low bits cleared, taken modulo the ring size. Start offsets are always multiples of 4.
- R5: Host port: writing with `hp_sel`=0 loads the read pointer and `hp_sel`=1 loads the configuration. The read offset is (pointer + 16) modulo the ring size. `buf_empty` is 1 exactly when the write offset equals the read offset.
- R6: Configuration bits: bit 0 accepts any unicast address, bit 1 own address, bit 2 multicast, bit 3 broadcast, bit 4 runts, bit 5 frames with errors, bit 6 linear mode, and bits 9:8 the size index. A frame whose address class is not enabled is dropped with no event, no header and no change of offset.
- R7: A runt is stored only when bit 4 is set. A frame with an alignment, CRC, symbol or too-long error is stored only when bit 5 is set.
- R8: With linear mode off, byte addresses fold modulo the ring size.
- R9: With linear mode on, bytes past the ring end go to the slack area at addresses ring..ring+SLACK-1. An accepted frame whose last byte would land at or beyond ring+SLACK is dropped as an overflow.
- R10: An accepted frame whose rounded footprint (L+7 with the low two bits cleared) is not smaller than the free space is dropped. `rx_ovf` pulses, no header is written and the write offset stays the same. The free space is the ring size minus the used bytes.
- R11: `rx_ok` pulses for one cycle when a good frame is committed and `rx_err` when an accepted bad frame is committed. Each pulse comes two clock edges after the edge that samples the last byte. At most one event is high in any cycle.
- R12: The ring size is BASE_BYTES shifted left by the size index (0, 1 or 2). Index 3 acts as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame; class and error flags valid |
| in_bcast | input | 1 | Broadcast destination |
| in_mcast | input | 1 | Multicast destination |
| in_phys | input | 1 | Destination matches own address |
| in_align_err | input | 1 | Alignment error |
| in_crc_err | input | 1 | CRC error |
| in_sym_err | input | 1 | Symbol error |
| hp_we | input | 1 | Host register write strobe |
| hp_sel | input | 1 | 0 selects read pointer, 1 configuration |
| hp_wdata | input | 16 | Host write data |
| rd_addr | input | 11 | Host byte read address into the buffer |
| rd_data | output | 8 | Buffer byte at `rd_addr` |
| buf_empty | output | 1 | Write offset equals read offset |
| rx_ok | output | 1 | Good frame committed |
| rx_err | output | 1 | Accepted bad frame committed |
| rx_ovf | output | 1 | Accepted frame dropped for lack of room |

## Verification
A wrong write offset cannot be seen directly. It shows up at the next committed frame, whose header lands at a different byte address than the bench model predicts. It also shows up as soon as the host moves its pointer to what should be the end of the data and `buf_empty` stays low. A wrong free-space or filter decision shows up two edges after the last byte, as an event that the scoreboard does not expect or as a missing one. Folding errors in ring or linear mode show in the readback of the final frame byte at its folded or slack address.

// File: rtl/rxr_pkg.sv
// Shared constants and types for the receive ring writer.
// Assumes: status and configuration bit positions are fixed by the host software contract.
package rxr_pkg;
    // header status word bit positions
    localparam int ST_GOOD  = 0;
    localparam int ST_ALIGN = 1;
    localparam int ST_CRC   = 2;
    localparam int ST_LONG  = 3;
    localparam int ST_RUNT  = 4;
    localparam int ST_SYM   = 5;
    localparam int ST_BCAST = 13;
    localparam int ST_PHYS  = 14;
    localparam int ST_MCAST = 15;

    // configuration register bit positions
    localparam int CF_ALL  = 0;
    localparam int CF_OWN  = 1;
    localparam int CF_MC   = 2;
    localparam int CF_BC   = 3;
    localparam int CF_RUNT = 4;
    localparam int CF_ERR  = 5;
    localparam int CF_WRAP = 6;
    localparam int CF_SZ   = 8;

    localparam int PTR_BIAS  = 16;
    localparam int HDR_BYTES = 4;

    // per-frame classification captured with the last byte
    typedef struct packed {
        logic bcast;
        logic mcast;
        logic phys;
        logic align;
        logic crc;
        logic sym;
    } rx_flags_t;
endpackage

// File: rtl/rxr_filter.sv
// Acceptance and status builder: turns frame flags and length into the header
// status word and decides whether the frame is stored.
// Assumes: flags and length are stable for the whole commit cycle.
module rxr_filter import rxr_pkg::*; #(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int LW      = 16
) (
    input  rx_flags_t       flags,
    input  logic [LW-1:0]   len,
    input  logic [5:0]      accept_bits,
    output logic [15:0]     status,
    output logic            accept,
    output logic            good
);
    logic runt, too_long, hard_err, addr_ok, unicast_other;

    // classify the frame and build its status word
    always_comb begin
        runt          = len < LW'(MIN_LEN);
        too_long      = len > LW'(MAX_LEN);
        hard_err      = flags.align | flags.crc | flags.sym | too_long;
        good          = !hard_err && !runt;
        status        = '0;
        status[ST_GOOD]  = good;
        status[ST_ALIGN] = flags.align;
        status[ST_CRC]   = flags.crc;
        status[ST_LONG]  = too_long;
        status[ST_RUNT]  = runt;
        status[ST_SYM]   = flags.sym;
        status[ST_BCAST] = flags.bcast;
        status[ST_PHYS]  = flags.phys;
        status[ST_MCAST] = flags.mcast;
        unicast_other = !flags.bcast && !flags.mcast && !flags.phys;
        addr_ok = (flags.bcast && accept_bits[CF_BC]) ||
                  (flags.mcast && accept_bits[CF_MC]) ||
                  (flags.phys  && (accept_bits[CF_OWN] || accept_bits[CF_ALL])) ||
                  (unicast_other && accept_bits[CF_ALL]);
        accept = addr_ok && (!hard_err || accept_bits[CF_ERR]) &&
                 (!runt || accept_bits[CF_RUNT]);
    end
endmodule

// File: rtl/rxr_space.sv
// Ring geometry and occupancy: ring size from the size index, biased read offset,
// free space and the empty flag.
// Assumes: PTR_W >= OW and the ring size is a power of two.
module rxr_space import rxr_pkg::*; #(
    parameter int BASE_BYTES = 256,
    parameter int OW         = 10,
    parameter int PTR_W      = 16
) (
    input  logic [1:0]       size_idx,
    input  logic [OW-1:0]    wr_off,
    input  logic [PTR_W-1:0] host_ptr,
    output logic [OW:0]      ring,
    output logic [OW-1:0]    mask,
    output logic [OW-1:0]    rd_off,
    output logic [OW:0]      free,
    output logic             empty
);
    logic [1:0]    sz;
    logic [OW-1:0] used;
    logic [PTR_W-1:0] unbiased;

    // derive ring size, read offset and free byte count
    always_comb begin
        sz       = (size_idx == 2'd3) ? 2'd2 : size_idx;
        ring     = (OW+1)'(BASE_BYTES) << sz;
        mask     = OW'(ring - 1'b1);
        unbiased = host_ptr + PTR_W'(PTR_BIAS);
        rd_off   = unbiased[OW-1:0] & mask;
        used     = (wr_off - rd_off) & mask;
        free     = ring - {1'b0, used};
        empty    = (wr_off == rd_off);
    end
endmodule

// File: rtl/rxr_store.sv
// Byte-wide buffer RAM with a frame-byte write port, a four-byte header write
// port and an asynchronous host read port.
// Assumes: the two write ports are never active in the same cycle.
module rxr_store #(
    parameter int DEPTH = 1040,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          byte_we,
    input  logic [AW-1:0] byte_addr,
    input  logic [7:0]    byte_data,
    input  logic          hdr_we,
    input  logic [AW-1:0] hdr_addr,
    input  logic [31:0]   hdr_word,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    // store frame bytes and header words
    always_ff @(posedge clk) begin
        if (byte_we)
            mem[byte_addr] <= byte_data;
        if (hdr_we)
            for (int k = 0; k < 4; k++)
                mem[hdr_addr + AW'(k)] <= hdr_word[8*k +: 8];
    end

    // host read of one byte
    always_comb
        rd_data = (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/rxr_writer.sv
// Receive ring writer top: places frame bytes after a reserved header slot,
// commits the header and advances the write offset once the last byte is in.
// Assumes: one idle input cycle follows every last byte; configuration changes
// only while no frame is in flight.
module rxr_writer import rxr_pkg::*; #(
    parameter int BASE_BYTES = 256,
    parameter int SLACK      = 16,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518,
    parameter int PTR_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_bcast,
    input  logic        in_mcast,
    input  logic        in_phys,
    input  logic        in_align_err,
    input  logic        in_crc_err,
    input  logic        in_sym_err,
    input  logic        hp_we,
    input  logic        hp_sel,
    input  logic [15:0] hp_wdata,
    input  logic [$clog2((BASE_BYTES<<2)+SLACK)-1:0] rd_addr,
    output logic [7:0]  rd_data,
    output logic        buf_empty,
    output logic        rx_ok,
    output logic        rx_err,
    output logic        rx_ovf
);
    localparam int RING_MAX = BASE_BYTES << 2;
    localparam int OW       = $clog2(RING_MAX);
    localparam int DEPTH    = RING_MAX + SLACK;
    localparam int AW       = $clog2(DEPTH);
    localparam int LW       = 16;
    localparam int XW       = LW + 2;

    logic [15:0]      cfg;
    logic [PTR_W-1:0] host_ptr;
    logic [OW-1:0]    wr_off, start_off, rd_off, mask, next_off;
    logic [OW:0]      ring, free;
    logic [LW-1:0]    cnt, idx, len_q;
    rx_flags_t        flags_q;
    logic             commit_q;
    logic [OW-1:0]    base;
    logic [XW-1:0]    q, pos, lim, foot;
    logic             wrap, fits, room, commit_ok, overflow;
    logic             byte_we;
    logic [AW-1:0]    byte_addr;
    logic [15:0]      status;
    logic             accept, good;

    rxr_space #(.BASE_BYTES(BASE_BYTES), .OW(OW), .PTR_W(PTR_W)) u_space (
        .size_idx(cfg[CF_SZ +: 2]), .wr_off(wr_off), .host_ptr(host_ptr),
        .ring(ring), .mask(mask), .rd_off(rd_off), .free(free), .empty(buf_empty)
    );

    rxr_filter #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LW(LW)) u_filter (
        .flags(flags_q), .len(len_q), .accept_bits(cfg[5:0]),
        .status(status), .accept(accept), .good(good)
    );

    rxr_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .byte_we(byte_we), .byte_addr(byte_addr), .byte_data(in_data),
        .hdr_we(commit_ok), .hdr_addr(AW'(start_off)), .hdr_word({len_q, status}),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // place the incoming byte and check it stays inside the free space
    always_comb begin
        wrap    = cfg[CF_WRAP];
        idx     = in_sof ? '0 : cnt;
        base    = in_sof ? wr_off : start_off;
        q       = XW'(idx) + XW'(HDR_BYTES);
        pos     = XW'(base) + q;
        lim     = XW'(ring) + XW'(SLACK);
        fits    = (q < XW'(free)) && (!wrap || pos < lim);
        byte_we = in_valid && fits;
        byte_addr = wrap ? AW'(pos) : AW'(pos[OW-1:0] & mask);
    end

    // decide the fate of the frame whose last byte was just taken
    always_comb begin
        foot      = (XW'(len_q) + XW'(HDR_BYTES + 3)) & ~XW'(3);
        room      = (foot < XW'(free)) &&
                    (!wrap || (XW'(start_off) + XW'(len_q) + XW'(3) < lim));
        commit_ok = commit_q && accept && room;
        overflow  = commit_q && accept && !room;
        next_off  = OW'(XW'(start_off) + foot) & mask;
    end

    // host register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            host_ptr <= ~PTR_W'(PTR_BIAS - 1);
        end else if (hp_we) begin
            if (hp_sel) cfg      <= hp_wdata;
            else        host_ptr <= PTR_W'(hp_wdata);
        end
    end

    // track byte count, frame start and the last-byte flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            start_off <= '0;
            len_q     <= '0;
            flags_q   <= '0;
            commit_q  <= 1'b0;
        end else begin
            commit_q <= in_valid && in_eof;
            if (in_valid) begin
                cnt <= idx + LW'(1);
                if (in_sof) start_off <= wr_off;
                if (in_eof) begin
                    len_q   <= idx + LW'(1);
                    flags_q <= '{bcast: in_bcast, mcast: in_mcast, phys: in_phys,
                                 align: in_align_err, crc: in_crc_err, sym: in_sym_err};
                end
            end
        end
    end

    // advance the write offset and raise the frame events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_off <= '0;
            rx_ok  <= 1'b0;
            rx_err <= 1'b0;
            rx_ovf <= 1'b0;
        end else begin
            if (commit_ok) wr_off <= next_off;
            rx_ok  <= commit_ok && good;
            rx_err <= commit_ok && !good;
            rx_ovf <= overflow;
        end
    end

    // R4: frame starts stay dword aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off[1:0] == 2'b00);
    // R11: never two events at once
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ok, rx_err, rx_ovf}));
    // R11: an ok event lasts one cycle
    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> !rx_ok);
    // R10: a dropped frame leaves the write offset alone
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> wr_off == $past(wr_off));
    // R5: a stored frame never makes the ring look empty
    a_r5_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_ok || rx_err) && !$past(hp_we)) |-> !buf_empty);
    // R2: the header cycle must see no input byte
    a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> !in_valid);
    // R12: free space is within one ring
    a_r12_free: assert property (@(posedge clk) disable iff (!rst_n)
        (free != '0) && (free <= ring));
endmodule

// File: tb/test_rxr_writer.sv
module test_rxr_writer;
    localparam int CF_ALL = 'h01, CF_OWN = 'h02, CF_MC = 'h04, CF_BC = 'h08;
    localparam int CF_RUNT = 'h10, CF_ERR = 'h20, CF_WRAP = 'h40;
    localparam int MAXL = 120, MINL = 64, BASE = 256, SLK = 16;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_data = 0;
    logic in_bcast = 0, in_mcast = 0, in_phys = 0;
    logic in_align_err = 0, in_crc_err = 0, in_sym_err = 0;
    logic hp_we = 0, hp_sel = 0;
    logic [15:0] hp_wdata = 0;
    logic [10:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic buf_empty, rx_ok, rx_err, rx_ovf;

    int checks = 0, failures = 0;
    int exp_q[$];
    int wr_m, ptr_m, cfg_m;
    bit finished = 0;

    always #10 clk = ~clk;

    rxr_writer #(.MAX_LEN(MAXL)) i_rxr_writer (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop the expected event whenever the design raises one (R11)
    always @(negedge clk) begin
        if (rst_n && (rx_ok || rx_err || rx_ovf)) begin
            int kind;
            kind = rx_ok ? 1 : rx_err ? 2 : 3;
            if (exp_q.size() == 0) chk(0, "R11 unexpected event", kind, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(kind == e, "R11 event kind", kind, e);
            end
        end
    end

    task automatic hp_write(input bit sel, input int val);
        @(negedge clk);
        hp_we = 1; hp_sel = sel; hp_wdata = 16'(val);
        @(negedge clk);
        hp_we = 0;
        if (sel) cfg_m = val; else ptr_m = val & 16'hFFFF;
    endtask

    task automatic rd_byte(input int addr, output int b);
        rd_addr = 11'(addr);
        #1 b = rd_data;
    endtask

    function automatic int ring_m();
        int s;
        s = (cfg_m >> 8) & 3;
        if (s == 3) s = 2;
        return BASE << s;
    endfunction

    // driver: compute the expected outcome, push it, then drive the frame
    task automatic send(input int len, input bit bc, mc, ph, al, cr, sy, input int seed);
        int ring, rd, used, free, foot, st, kind, start, p, b;
        bit runt, tl, hard, good, addr_ok, acc, wrap, stored;
        ring = ring_m();
        wrap = (cfg_m & CF_WRAP) != 0;
        rd = (ptr_m + 16) % ring;
        used = (wr_m - rd + ring) % ring;
        free = ring - used;
        runt = len < MINL; tl = len > MAXL;
        hard = al | cr | sy | tl; good = !hard && !runt;
        st = int'(good) | (int'(al) << 1) | (int'(cr) << 2) | (int'(tl) << 3) |
             (int'(runt) << 4) | (int'(sy) << 5) | (int'(bc) << 13) |
             (int'(ph) << 14) | (int'(mc) << 15);
        addr_ok = (bc && (cfg_m & CF_BC) != 0) || (mc && (cfg_m & CF_MC) != 0) ||
                  (ph && (cfg_m & (CF_OWN | CF_ALL)) != 0) ||
                  (!bc && !mc && !ph && (cfg_m & CF_ALL) != 0);
        acc = addr_ok && (!hard || (cfg_m & CF_ERR) != 0) && (!runt || (cfg_m & CF_RUNT) != 0);
        foot = (len + 7) & ~3;
        start = wr_m;
        stored = 0;
        if (acc) begin
            if (foot >= free || (wrap && start + 3 + len >= ring + SLK)) kind = 3;
            else begin kind = good ? 1 : 2; stored = 1; end
            exp_q.push_back(kind);
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = 8'(seed + 3 * i);
            in_sof = (i == 0); in_eof = (i == len - 1);
            in_bcast = bc; in_mcast = mc; in_phys = ph;
            in_align_err = al; in_crc_err = cr; in_sym_err = sy;
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (3) @(negedge clk);
        if (stored) begin
            wr_m = (start + foot) % ring;
            // R2 R3: header bytes little-endian {len, status}
            for (int k = 0; k < 4; k++) begin
                int e;
                e = ((k < 2) ? (st >> (8 * k)) : (len >> (8 * (k - 2)))) & 8'hFF;
                rd_byte(start + k, b);
                chk(b == e, "R2 R3 header byte", b, e);
            end
            // R8 R9: last frame byte at folded or slack address
            p = start + 4 + len - 1;
            if (!wrap) p = p % ring;
            rd_byte(p, b);
            chk(b == ((seed + 3 * (len - 1)) & 8'hFF), "R8 R9 last byte", b,
                (seed + 3 * (len - 1)) & 8'hFF);
        end
        // R5 R4: empty flag follows the modelled offsets
        chk(buf_empty == (wr_m == (ptr_m + 16) % ring), "R5 R4 empty flag",
            int'(buf_empty), int'(wr_m == (ptr_m + 16) % ring));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        wr_m = 0; ptr_m = 16'hFFF0; cfg_m = 0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(buf_empty == 1, "R1 empty after reset", int'(buf_empty), 1);
        chk({rx_ok, rx_err, rx_ovf} == 3'b000, "R1 no events", int'({rx_ok, rx_err, rx_ovf}), 0);
        // R1 R6: config resets to accept nothing
        send(70, 0, 0, 1, 0, 0, 0, 5);
        hp_write(1, CF_BC | CF_OWN);
        send(70, 0, 0, 1, 0, 0, 0, 17);               // R2 R4 good own frame
        hp_write(0, wr_m - 16);                         // R5 bias: consume all
        chk(buf_empty == 1, "R5 empty after pointer write", int'(buf_empty), 1);
        send(65, 0, 1, 0, 0, 0, 0, 9);                 // R6 multicast disabled
        send(40, 1, 0, 0, 0, 0, 0, 33);                // R7 runt disabled
        hp_write(1, CF_BC | CF_OWN | CF_RUNT);
        send(40, 1, 0, 0, 0, 0, 0, 33);                // R7 runt stored
        hp_write(1, CF_BC | CF_OWN | CF_RUNT | CF_ERR);
        send(66, 0, 0, 1, 0, 1, 0, 71);                // R7 crc error stored
        send(121, 0, 0, 1, 0, 0, 0, 2);                // R8 too long, folds past end
        send(64, 0, 0, 1, 0, 0, 0, 90);                // R10 no room
        hp_write(0, wr_m - 16);
        send(64, 0, 0, 0, 0, 0, 0, 44);                // R6 other unicast dropped
        hp_write(1, CF_ALL | CF_MC | CF_ERR);
        send(64, 0, 0, 0, 0, 0, 0, 44);                // R6 any-unicast mode
        send(64, 0, 1, 0, 0, 0, 1, 61);                // R3 R6 multicast with symbol error
        hp_write(0, wr_m - 16);
        hp_write(1, CF_OWN | CF_WRAP);
        send(64, 0, 0, 1, 0, 0, 0, 120);               // R9 into slack
        hp_write(0, wr_m - 16);
        send(100, 0, 0, 1, 0, 0, 0, 7);
        send(96, 0, 0, 1, 0, 0, 0, 8);
        hp_write(0, wr_m - 16);
        send(64, 0, 0, 1, 0, 1, 1, 3);                 // R9 beyond slack: crc not accepted, no event
        send(64, 0, 0, 1, 0, 0, 0, 3);                 // R9 beyond slack -> overflow
        do_reset();
        hp_write(1, CF_OWN | (1 << 8));                 // R12 size index 1
        send(120, 0, 0, 1, 0, 0, 0, 11);
        send(120, 0, 0, 1, 0, 0, 0, 12);
        send(100, 0, 0, 1, 0, 0, 0, 13);               // R12 no fold below 512
        hp_write(1, CF_OWN | (3 << 8));                 // R12 index 3 acts as 2
        send(120, 0, 0, 1, 0, 0, 0, 14);
        chk(exp_q.size() == 0, "R11 missing events", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule